// File: doc/BRIEF.md
# Latch-Based Register File

This block is a small storage array of 32 words, each 8 bits wide, built from level-sensitive latch cells instead of edge-triggered flops. A 5-bit address is decoded into 32 one-hot row lines. Each row line is the AND of five address literals, some true and some complemented. Row numbering is reversed: address 0 drives the highest-numbered row line, and in general the row index is 31 minus the address. A single mode pin chooses between writing and reading the addressed word.

In write mode the selected row's latches are transparent, so the stored word follows the data input for as long as the mode pin stays high. The word keeps the last value it saw when the mode pin falls or the address moves to another row. In read mode no row is enabled for writing. The output port presents the addressed word and an output-enable is raised, which stands in for the shared bidirectional bus. Nothing in the block is clocked and nothing is reset, so a word holds an unknown value until it is first written. The interface has no flow control, because each access completes as soon as its inputs settle. For that reason the pins are plain levels and not a valid/ready stream.

Top module: `latch_regfile`

## Requirements
- R1: The array holds 32 independent 8-bit words, addressed by a 5-bit address. A value written at one address reads back unchanged at that address.
- R2: For any address, exactly one of the 32 internal row lines is asserted.
- R3: Address a asserts row line 31 − a. For example, address 0 asserts row 31 and address 2 asserts row 29.
- R4: When `wr_mode` = 1, the addressed word is transparent and follows `din`. After `wr_mode` falls, the word holds the last `din` value present before the fall.
- R5: A write changes only the addressed word and leaves every other word unchanged. At most one row is write-enabled at a time, and no row is write-enabled while `wr_mode` = 0.
- R6: When `wr_mode` = 0 (read), `dout_oe` = 1 and `dout` equals the word stored at `addr`. Reading never alters any word.
- R7: When `wr_mode` = 1, `dout_oe` = 0 and `dout` = 8'h00.
- R8: If `addr` changes while `wr_mode` = 1, the word that was left holds the `din` value present when the address moved away. The newly addressed word then follows `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 5 | Word address; row line 31 − addr is selected |
| wr_mode | input | 1 | 1 = write (selected word transparent), 0 = read |
| din | input | 8 | Write data |
| dout | output | 8 | Read data; 0 when not reading |
| dout_oe | output | 1 | High while reading; models driving the shared bus |

## Verification
The assertions assume that `addr` and `wr_mode` are always 0 or 1 and never unknown. They also assume that the combinational decode has settled by the time each check is evaluated. The bench keeps inside these assumptions in two ways. It gives every input a known value from time zero. It changes only one class of input per step, so `din` is never changed in the same step that `wr_mode` falls or `addr` moves during a write. Because the stored words start unknown, the bench writes all 32 words before it reads any of them back.

// File: rtl/latch_regfile_pkg.sv
package latch_regfile_pkg;
  localparam int unsigned RF_ADDR_W = 5;
  localparam int unsigned RF_DATA_W = 8;

  typedef enum logic {
    RF_READ  = 1'b0,
    RF_WRITE = 1'b1
  } rf_mode_e;
endpackage

// File: rtl/rf_row_decoder.sv
module rf_row_decoder #(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  row_sel
);
  // Each row is the AND of ADDR_W literals; row r answers address DEPTH-1-r.
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    localparam logic [ADDR_W-1:0] CODE = ADDR_W'(DEPTH - 1 - r);
    logic [ADDR_W-1:0] lit;
    for (genvar b = 0; b < ADDR_W; b++) begin : g_lit
      if (CODE[b]) begin : g_true
        assign lit[b] = addr[b];
      end else begin : g_comp
        assign lit[b] = ~addr[b];
      end
    end
    assign row_sel[r] = &lit;
  end
endmodule

// File: rtl/rf_latch_word.sv
module rf_latch_word #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              row_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  // One transparent latch per bit, all sharing the row enable.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_latch begin
      if (row_en) q[b] <= d[b];
    end
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic [DEPTH-1:0]             row_sel,
  input  logic [DEPTH-1:0][DATA_W-1:0] words,
  input  logic                         rd_en,
  output logic [DATA_W-1:0]            q
);
  // AND-OR selection keyed by the one-hot rows, so no second decoder is needed.
  logic [DEPTH-1:0][DATA_W-1:0] masked;
  logic [DEPTH:0][DATA_W-1:0]   acc;

  assign acc[0] = '0;
  for (genvar r = 0; r < DEPTH; r++) begin : g_or
    assign masked[r] = words[r] & {DATA_W{row_sel[r]}};
    assign acc[r+1]  = acc[r] | masked[r];
  end

  assign q = rd_en ? acc[DEPTH] : '0;
endmodule

// File: rtl/latch_regfile.sv
module latch_regfile
  import latch_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = RF_ADDR_W,
  parameter int unsigned DATA_W = RF_DATA_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  rf_mode_e mode;
  logic [DEPTH-1:0]             row_sel;
  logic [DEPTH-1:0]             row_we;
  logic [DEPTH-1:0][DATA_W-1:0] words;
  logic                         rd_en;

  assign mode  = rf_mode_e'(wr_mode);
  assign rd_en = (mode == RF_READ);

  rf_row_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .row_sel (row_sel)
  );

  for (genvar r = 0; r < DEPTH; r++) begin : g_word
    assign row_we[r] = row_sel[r] & (mode == RF_WRITE);
    rf_latch_word #(.DATA_W(DATA_W)) u_word (
      .row_en (row_we[r]),
      .d      (din),
      .q      (words[r])
    );
  end

  rf_read_mux #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mux (
    .row_sel (row_sel),
    .words   (words),
    .rd_en   (rd_en),
    .q       (dout)
  );

  assign dout_oe = rd_en;
endmodule

// File: rtl/latch_regfile_checker.sv
module latch_regfile_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0] addr,
  input logic              wr_mode,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic [DEPTH-1:0]  row_sel,
  input logic [DEPTH-1:0]  row_we
);
  always_comb begin
    p_one_row_r2: assert ($onehot(row_sel))
      else $error("row lines not one-hot: %h", row_sel);
    p_reverse_map_r3: assert (row_sel[DEPTH - 1 - int'(addr)])
      else $error("addr %0d did not select row %0d", addr, DEPTH - 1 - int'(addr));
    p_single_write_r5: assert ($countones(row_we) <= 1)
      else $error("more than one row write-enabled: %h", row_we);
    if (!wr_mode) begin
      p_read_no_write_r5: assert (row_we == '0)
        else $error("row enabled for write during read: %h", row_we);
    end
    if (!dout_oe) begin
      p_quiet_bus_r7: assert (dout == '0)
        else $error("dout %h while output disabled", dout);
    end
  end
endmodule

bind latch_regfile latch_regfile_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .addr    (addr),
  .wr_mode (wr_mode),
  .dout    (dout),
  .dout_oe (dout_oe),
  .row_sel (row_sel),
  .row_we  (row_we)
);

// File: tb/latch_regfile_bench.sv
module latch_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_mode = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  int model [N];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latch_regfile u_latch_regfile (
    .addr(addr), .wr_mode(wr_mode), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_word(int a, int d);
    wr_mode = 1'b0; step();
    addr = AW'(a); din = DW'(d); step();
    wr_mode = 1'b1; step();
    wr_mode = 1'b0; step();
    model[a] = d & 8'hFF;
  endtask

  task automatic read_check(string req, int a);
    wr_mode = 1'b0; addr = AW'(a); step();
    check(req, int'(dout_oe), 1);
    check(req, int'(dout), model[a]);
  endtask

  initial begin
    step();
    // R7: write mode keeps the output quiet
    check("R7 oe", int'(dout_oe), 0);
    check("R7 dout", int'(dout), 0);

    // R1 / R2 / R3: fill every word, read each back; distinct rows per address
    for (int a = 0; a < N; a++) write_word(a, (a * 37 + 5) & 255);
    for (int a = 0; a < N; a++) read_check("R1 R2 R3 sweep", a);

    // R6: repeated reads alter nothing
    for (int a = N - 1; a >= 0; a--) read_check("R6 reread", a);

    // R4: transparency then hold of last value
    wr_mode = 1'b0; addr = AW'(9); din = 8'h11; step();
    wr_mode = 1'b1; step();
    check("R7 during write", int'(dout), 0);
    din = 8'h22; step();
    din = 8'hA7; step();
    wr_mode = 1'b0; step();
    model[9] = 8'hA7;
    check("R4 hold", int'(dout), 8'hA7);
    din = 8'h3C; step();
    check("R4 read ignores din", int'(dout), 8'hA7);

    // R8: retarget while writing
    wr_mode = 1'b0; addr = AW'(3); din = 8'h5A; step();
    wr_mode = 1'b1; step();
    addr = AW'(4); step();
    din = 8'hC3; step();
    wr_mode = 1'b0; step();
    model[3] = 8'h5A; model[4] = 8'hC3;
    read_check("R8 left word", 3);
    read_check("R8 new word", 4);

    // R5: single writes at the extremes, everything else untouched
    write_word(0, 8'hFF);
    write_word(31, 8'h00);
    write_word(16, 8'h81);
    for (int a = 0; a < N; a++) read_check("R5 others kept", a);

    // R7 again with a nonzero stored word at the address
    wr_mode = 1'b0; addr = AW'(16); din = 8'h81; step();
    wr_mode = 1'b1; step();
    check("R7 oe low", int'(dout_oe), 0);
    check("R7 zero", int'(dout), 0);
    wr_mode = 1'b0; step();
    read_check("R4 R6 same value", 16);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule